// File: doc/BRIEF.md
# Dual Digital Potentiometer Serial Command Controller

This block is the control logic of a two-channel, 256-position digital potentiometer. A host talks to it over a four-wire serial link made of a serial clock, an active-low select, a data input and a data output. Each frame opens with an addressing byte and an instruction byte. Some commands then carry a third data byte in either direction. Each channel has one live wiper code, which drives the `wiper0`/`wiper1` outputs, and four stored 8-bit presets. Commands move values between the host, the live codes and the presets, for one channel or for both channels at once. A stepping mode nudges one wiper by one position per serial clock.

Preset stores stand in for a nonvolatile write. Each one starts a countdown of `NV_CYCLES` system clocks, and a busy flag is visible through a status read. The serial inputs are synchronised into the system clock domain. Serial-clock rising edges are detected there, so the serial clock must run well below the system clock. Input bits are taken on serial-clock rising edges. Read data is presented so that the host can sample it just before each rising edge.

Top module: `dpot_ctrl`

## Requirements
- R1: A frame is acted on only if its first byte equals {4'b0101, strap_addr[1:0], 2'b00}. Any other first byte makes the rest of the frame a no-op: wipers, presets and busy state are untouched and spi_sdo stays 0.
- R2: The second byte is laid out as opcode in bits 7:4, preset select in bits 3:2 (00 → preset 0, 01 → 1, 10 → 2, 11 → 3), bit 1 ignored, and channel select in bit 0 (0 → wiper0, 1 → wiper1). A command addressed to one channel never alters the other channel.
- R3: Opcode 1010 (load wiper) takes a third byte, MSB first. At the end of the 24th bit that byte becomes the selected channel's wiper output.
- R4: Opcode 1001 (read wiper) and opcode 1011 (read preset) return the value MSB first on spi_sdo. Data bit 7-k is valid before the (17+k)-th serial-clock rising edge. spi_sdo is 0 whenever select is inactive.
- R5: Opcode 1100 (store preset) takes a third byte and writes it into the selected preset of the selected channel. It can be read back with opcode 1011.
- R6: Two-byte opcode 1101 copies the selected preset into the selected wiper. Two-byte opcode 1110 copies the selected wiper into the selected preset.
- R7: Two-byte opcode 0001 copies preset number RB:RA into the wiper on both channels. Two-byte opcode 1000 copies both wipers into preset number RB:RA of their own channels.
- R8: Every preset store (1100, 1110, 1000) sets the busy flag for NV_CYCLES system clocks. Opcode 0101 (status) returns a third byte whose bit 0 is the busy flag and whose other bits are 0.
- R9: While busy, preset stores are dropped and do not extend the busy time. Status and read commands are still answered.
- R10: After opcode 0010, each further serial-clock rising edge moves the selected wiper up one step when the data input is 1 and down one step when it is 0. This continues until select goes inactive.
- R11: Stepping saturates at 0 and 255 and never wraps.
- R12: Deasserting select before a command's last bit aborts the frame with no register change. The next frame counts bits from zero.
- R13: After reset both wipers, all presets, and the busy flag are 0, and spi_sdo is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 2 | Pin-strapped device address compared with bits 3:2 of the first byte |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host |
| wiper0 | output | 8 | Live wiper code of channel 0 |
| wiper1 | output | 8 | Live wiper code of channel 1 |

## Verification
The hardest state to reach from the ports is a preset store that arrives while an earlier store is still inside its write window. Only then does the drop-while-busy rule act, and the dropped value is only visible after the window has closed. The bench sets a long write window, issues a store, reads status at once to confirm the busy flag, and sends a second store to the same preset with a different value. It then waits out the window, reads status again, and reads the preset back, expecting the first value. Saturation is reached by first loading a wiper next to 255 or 0 and then streaming more steps than the remaining headroom.

// File: rtl/dpot_pkg.sv
`timescale 1ns/1ps
package dpot_pkg;
  localparam int TAP_W = 8;
  localparam int N_POT = 2;
  localparam int N_DR  = 4;
  localparam int SEL_W = $clog2(N_DR);

  typedef logic [3:0] op_t;
  localparam op_t OP_RD_WCR   = 4'b1001;
  localparam op_t OP_WR_WCR   = 4'b1010;
  localparam op_t OP_RD_DR    = 4'b1011;
  localparam op_t OP_WR_DR    = 4'b1100;
  localparam op_t OP_DR2WCR   = 4'b1101;
  localparam op_t OP_WCR2DR   = 4'b1110;
  localparam op_t OP_G_DR2WCR = 4'b0001;
  localparam op_t OP_G_WCR2DR = 4'b1000;
  localparam op_t OP_STEP     = 4'b0010;
  localparam op_t OP_STATUS   = 4'b0101;

  localparam logic [3:0] FAMILY_CODE = 4'b0101;

  typedef enum logic [2:0] {PH_ID, PH_INS, PH_DATA, PH_STEP, PH_SKIP} phase_t;
endpackage

// File: rtl/dpot_sync.sv
`timescale 1ns/1ps
module dpot_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= {2{RST_VAL[g]}};
      else        stage <= {stage[0], d[g]};
    end
    assign q[g] = stage[1];
  end
endmodule

// File: rtl/dpot_nvtimer.sv
`timescale 1ns/1ps
module dpot_nvtimer #(
  parameter int NV_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(NV_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start && cnt_q == '0) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_W'(NV_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dpot_bank.sv
`timescale 1ns/1ps
module dpot_bank
  import dpot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_wcr,
  input  logic [TAP_W-1:0] wcr_in,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             ld_dr,
  input  logic [SEL_W-1:0] dr_sel,
  input  logic [TAP_W-1:0] dr_in,
  output logic [TAP_W-1:0] wcr_q,
  output logic [TAP_W-1:0] dr_q
);
  localparam logic [TAP_W-1:0] TOP = '1;

  logic [TAP_W-1:0] wcr_d;
  logic             wcr_en;
  logic [TAP_W-1:0] dr_mem [N_DR];

  always_comb begin
    wcr_en = 1'b1;
    wcr_d  = wcr_q;
    if (ld_wcr)                       wcr_d = wcr_in;
    else if (step_up && wcr_q != TOP) wcr_d = wcr_q + 1'b1;
    else if (step_dn && wcr_q != '0)  wcr_d = wcr_q - 1'b1;
    else                              wcr_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcr_q <= '0;
    else if (wcr_en) wcr_q <= wcr_d;
  end

  for (genvar i = 0; i < N_DR; i++) begin : g_dr
    logic dr_en;
    assign dr_en = ld_dr && (dr_sel == SEL_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dr_mem[i] <= '0;
      else if (dr_en) dr_mem[i] <= dr_in;
    end
  end

  assign dr_q = dr_mem[dr_sel];
endmodule

// File: rtl/dpot_ctrl.sv
`timescale 1ns/1ps
module dpot_ctrl
  import dpot_pkg::*;
#(
  parameter int NV_CYCLES = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       strap_addr,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_sdi,
  output logic             spi_sdo,
  output logic [TAP_W-1:0] wiper0,
  output logic [TAP_W-1:0] wiper1
);
  logic sck_s, csn_s, sdi_s, sck_q, rise;

  dpot_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sck, spi_cs_n, spi_sdi}),
    .q({sck_s, csn_s, sdi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end
  assign rise = sck_s && !sck_q && !csn_s;

  phase_t           phase_q, phase_d;
  logic [2:0]       cnt_q, cnt_d;
  logic [6:0]       in_q, in_d;
  logic [7:0]       in_nx;
  op_t              op_q, op_d;
  logic [SEL_W-1:0] rs_q, rs_d, sel;
  logic             pot_q, pot_d, pot_now;
  logic [7:0]       out_q, out_d;
  logic             rd_q, rd_d;

  logic [N_POT-1:0] ld_wcr, ld_dr, step_up, step_dn;
  logic             nv_go, wip;
  logic [TAP_W-1:0] wcr_src [N_POT];
  logic [TAP_W-1:0] dr_src  [N_POT];
  logic [TAP_W-1:0] wcr_w   [N_POT];
  logic [TAP_W-1:0] drq_w   [N_POT];

  assign in_nx   = {in_q, sdi_s};
  assign sel     = (phase_q == PH_INS) ? in_nx[3:2] : rs_q;
  assign pot_now = (phase_q == PH_INS) ? in_nx[0]   : pot_q;

  always_comb begin
    phase_d = phase_q; cnt_d = cnt_q; in_d = in_q;
    op_d = op_q; rs_d = rs_q; pot_d = pot_q;
    out_d = out_q; rd_d = rd_q;
    ld_wcr = '0; ld_dr = '0; step_up = '0; step_dn = '0; nv_go = 1'b0;
    for (int p = 0; p < N_POT; p++) begin
      wcr_src[p] = drq_w[p];
      dr_src[p]  = wcr_w[p];
    end
    if (csn_s) begin
      phase_d = PH_ID; cnt_d = '0; rd_d = 1'b0;
    end else if (rise) begin
      cnt_d = cnt_q + 1'b1;
      in_d  = in_nx[6:0];
      unique case (phase_q)
        PH_ID: if (cnt_q == 3'd7)
          phase_d = (in_nx == {FAMILY_CODE, strap_addr, 2'b00}) ? PH_INS : PH_SKIP;
        PH_INS: if (cnt_q == 3'd7) begin
          op_d = in_nx[7:4]; rs_d = in_nx[3:2]; pot_d = in_nx[0];
          phase_d = PH_SKIP;
          case (in_nx[7:4])
            OP_RD_WCR:  begin phase_d = PH_DATA; rd_d = 1'b1; out_d = wcr_w[pot_now]; end
            OP_RD_DR:   begin phase_d = PH_DATA; rd_d = 1'b1; out_d = drq_w[pot_now]; end
            OP_STATUS:  begin phase_d = PH_DATA; rd_d = 1'b1; out_d = {7'b0, wip}; end
            OP_WR_WCR, OP_WR_DR: phase_d = PH_DATA;
            OP_STEP:    phase_d = PH_STEP;
            OP_DR2WCR:  ld_wcr[pot_now] = 1'b1;
            OP_WCR2DR:  begin ld_dr[pot_now] = !wip; nv_go = 1'b1; end
            OP_G_DR2WCR: ld_wcr = '1;
            OP_G_WCR2DR: begin ld_dr = {N_POT{!wip}}; nv_go = 1'b1; end
            default: ;
          endcase
        end
        PH_DATA: begin
          out_d = {out_q[6:0], 1'b0};
          if (cnt_q == 3'd7) begin
            phase_d = PH_SKIP; rd_d = 1'b0;
            if (op_q == OP_WR_WCR) begin
              ld_wcr[pot_q] = 1'b1; wcr_src[pot_q] = in_nx;
            end else if (op_q == OP_WR_DR) begin
              ld_dr[pot_q] = !wip; dr_src[pot_q] = in_nx; nv_go = 1'b1;
            end
          end
        end
        PH_STEP: begin
          step_up[pot_q] = sdi_s;
          step_dn[pot_q] = !sdi_s;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ID; cnt_q <= '0; in_q <= '0; op_q <= '0;
      rs_q <= '0; pot_q <= 1'b0; out_q <= '0; rd_q <= 1'b0;
    end else begin
      phase_q <= phase_d; cnt_q <= cnt_d; in_q <= in_d; op_q <= op_d;
      rs_q <= rs_d; pot_q <= pot_d; out_q <= out_d; rd_q <= rd_d;
    end
  end

  dpot_nvtimer #(.NV_CYCLES(NV_CYCLES)) u_nv (
    .clk(clk), .rst_n(rst_n), .start(nv_go), .busy(wip)
  );

  for (genvar p = 0; p < N_POT; p++) begin : g_pot
    dpot_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .ld_wcr(ld_wcr[p]), .wcr_in(wcr_src[p]),
      .step_up(step_up[p]), .step_dn(step_dn[p]),
      .ld_dr(ld_dr[p]), .dr_sel(sel), .dr_in(dr_src[p]),
      .wcr_q(wcr_w[p]), .dr_q(drq_w[p])
    );
  end

  assign spi_sdo = rd_q && out_q[7];
  assign wiper0  = wcr_w[0];
  assign wiper1  = wcr_w[1];
endmodule

// File: rtl/dpot_ctrl_chk.sv
`timescale 1ns/1ps
module dpot_ctrl_chk
  import dpot_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             csn_s,
  input logic             sdo,
  input logic [TAP_W-1:0] wiper0,
  input logic [TAP_W-1:0] wiper1,
  input logic [N_POT-1:0] ld_wcr,
  input logic [N_POT-1:0] ld_dr,
  input logic [N_POT-1:0] step_up,
  input logic [N_POT-1:0] step_dn,
  input logic             wip
);
  localparam logic [TAP_W-1:0] TOP = '1;

  AST_IDLE_WIPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> ($stable(wiper0) && $stable(wiper1))); // R12
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !sdo); // R4
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up[0] && wiper0 == TOP) |=> wiper0 == TOP); // R11
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn[1] && wiper1 == '0) |=> wiper1 == '0); // R11
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up[0] && wiper0 != TOP) |=> wiper0 == $past(wiper0) + 8'd1); // R10
  AST_STORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|ld_dr) |=> wip); // R8
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_wcr[0], step_up[0], step_dn[0]})); // R10
endmodule

bind dpot_ctrl dpot_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .sdo(spi_sdo),
  .wiper0(wiper0), .wiper1(wiper1), .ld_wcr(ld_wcr), .ld_dr(ld_dr),
  .step_up(step_up), .step_dn(step_dn), .wip(wip)
);

// File: tb/dpot_ctrl_tb.sv
`timescale 1ns/1ps
module dpot_ctrl_tb;
  localparam int         NV    = 1500;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [3:0] RDW = 4'b1001, WRW = 4'b1010, RDD = 4'b1011, WRD = 4'b1100,
                         D2W = 4'b1101, W2D = 4'b1110, GD2W = 4'b0001, GW2D = 4'b1000,
                         STP = 4'b0010, STA = 4'b0101;

  logic clk = 1'b0;
  logic rst_n, sck, csn, sdi;
  logic sdo;
  logic [7:0] w0, w1, rx;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dpot_ctrl #(.NV_CYCLES(NV)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_addr(STRAP), .spi_sck(sck),
    .spi_cs_n(csn), .spi_sdi(sdi), .spi_sdo(sdo), .wiper0(w0), .wiper1(w1)
  );

  function automatic logic [7:0] idb();
    return {4'b0101, STRAP, 2'b00};
  endfunction
  function automatic logic [7:0] ins(logic [3:0] op, logic [1:0] rs, logic pot);
    return {op, rs, 1'b0, pot};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic o);
    sdi = b; #80; o = sdo; sck = 1'b1; #80; sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) xbit(tx[i], r[i]);
  endtask

  task automatic frame(input logic [7:0] b0, b1, b2, input int n, output logic [7:0] r);
    logic [7:0] d;
    r = 8'h00;
    csn = 1'b0; #100;
    xbyte(b0, d);
    if (n > 1) xbyte(b1, d);
    if (n > 2) xbyte(b2, r);
    #100; csn = 1'b1; #300;
  endtask

  task automatic steps(input logic pot, input logic [15:0] dir, input int n);
    logic [7:0] d;
    logic o;
    csn = 1'b0; #100;
    xbyte(idb(), d);
    xbyte(ins(STP, 2'b00, pot), d);
    for (int i = 0; i < n; i++) xbit(dir[i], o);
    #100; csn = 1'b1; #300;
  endtask

  task automatic t_reset();
    chk("R13 wiper0", w0, 8'h00);
    chk("R13 wiper1", w1, 8'h00);
    chk("R13 sdo", {7'b0, sdo}, 8'h00);
  endtask

  task automatic t_wcr();
    frame(idb(), ins(WRW, 2'b00, 1'b0), 8'hA5, 3, rx);
    chk("R3 wiper0 load", w0, 8'hA5);
    chk("R2 wiper1 untouched", w1, 8'h00);
    frame(idb(), {WRW, 2'b11, 1'b1, 1'b1}, 8'h3C, 3, rx);
    chk("R2 pot1 load, bit1 ignored", w1, 8'h3C);
    chk("R2 wiper0 untouched", w0, 8'hA5);
    frame(idb(), ins(RDW, 2'b00, 1'b0), 8'h00, 3, rx);
    chk("R4 read wiper0", rx, 8'hA5);
    chk("R4 sdo idle", {7'b0, sdo}, 8'h00);
  endtask

  task automatic t_store_busy();
    frame(idb(), ins(WRD, 2'b10, 1'b1), 8'h77, 3, rx);
    frame(idb(), ins(STA, 2'b00, 1'b0), 8'h00, 3, rx);
    chk("R8 status busy", rx, 8'h01);
    frame(idb(), ins(WRD, 2'b10, 1'b1), 8'h11, 3, rx);
    frame(idb(), ins(RDD, 2'b10, 1'b1), 8'h00, 3, rx);
    chk("R9 read while busy", rx, 8'h77);
    #16000;
    frame(idb(), ins(STA, 2'b00, 1'b0), 8'h00, 3, rx);
    chk("R8 status idle", rx, 8'h00);
    frame(idb(), ins(RDD, 2'b10, 1'b1), 8'h00, 3, rx);
    chk("R5 R9 preset kept", rx, 8'h77);
  endtask

  task automatic t_xfer();
    frame(idb(), ins(D2W, 2'b10, 1'b1), 8'h00, 2, rx);
    chk("R6 preset to wiper1", w1, 8'h77);
    chk("R6 wiper0 untouched", w0, 8'hA5);
    frame(idb(), ins(W2D, 2'b01, 1'b0), 8'h00, 2, rx);
    #16000;
    frame(idb(), ins(RDD, 2'b01, 1'b0), 8'h00, 3, rx);
    chk("R6 wiper0 to preset1", rx, 8'hA5);
  endtask

  task automatic t_global();
    frame(idb(), ins(GW2D, 2'b11, 1'b0), 8'h00, 2, rx);
    #16000;
    frame(idb(), ins(WRW, 2'b00, 1'b0), 8'h00, 3, rx);
    frame(idb(), ins(WRW, 2'b00, 1'b1), 8'h00, 3, rx);
    chk("R7 cleared wiper0", w0, 8'h00);
    frame(idb(), ins(GD2W, 2'b11, 1'b0), 8'h00, 2, rx);
    chk("R7 global load wiper0", w0, 8'hA5);
    chk("R7 global load wiper1", w1, 8'h77);
  endtask

  task automatic t_addr();
    frame({4'b0101, 2'b01, 2'b00}, ins(WRW, 2'b00, 1'b0), 8'h12, 3, rx);
    chk("R1 wrong address", w0, 8'hA5);
    frame({4'b0110, STRAP, 2'b00}, ins(WRW, 2'b00, 1'b0), 8'h12, 3, rx);
    chk("R1 wrong family", w0, 8'hA5);
    frame({4'b0101, 2'b01, 2'b00}, ins(RDW, 2'b00, 1'b0), 8'h00, 3, rx);
    chk("R1 no read reply", rx, 8'h00);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    logic o;
    csn = 1'b0; #100;
    xbyte(idb(), d);
    xbyte(ins(WRW, 2'b00, 1'b0), d);
    for (int i = 0; i < 4; i++) xbit(1'b1, o);
    #100; csn = 1'b1; #300;
    chk("R12 aborted write", w0, 8'hA5);
    frame(idb(), ins(WRW, 2'b00, 1'b0), 8'hFD, 3, rx);
    chk("R12 fresh frame", w0, 8'hFD);
  endtask

  task automatic t_step();
    steps(1'b0, 16'h001F, 5);
    chk("R11 top saturation", w0, 8'hFF);
    chk("R2 wiper1 kept", w1, 8'h77);
    steps(1'b0, 16'h0000, 3);
    chk("R10 step down", w0, 8'hFC);
    steps(1'b0, 16'h0005, 4);
    chk("R10 mixed steps", w0, 8'hFC);
    frame(idb(), ins(WRW, 2'b00, 1'b1), 8'h01, 3, rx);
    steps(1'b1, 16'h0000, 3);
    chk("R11 bottom saturation", w1, 8'h00);
  endtask

  initial begin
    sck = 1'b0; csn = 1'b1; sdi = 1'b0; rst_n = 1'b0;
    #33 rst_n = 1'b1;
    #100;
    t_reset();
    t_wcr();
    t_store_busy();
    t_xfer();
    t_global();
    t_addr();
    t_abort();
    t_step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule